// File: doc/BRIEF.md
# Programmable Memory Bank Chip-Select Controller

This block sits between a 32-bit system bus and up to eight external memory or peripheral banks. At the start of each bus cycle it compares the upper address bits with the base of every enabled bank. Each compare is masked to that bank's power-of-two block size. The bank that wins drives its own chip-select line, and the bus cycle is held for that bank's programmed wait-state count. The block then returns a single-cycle transfer acknowledge. While the access is in progress it also reports the bank's port width, so the bus interface can split wide transfers. It drives four byte-write-enable lanes and one output-enable.

Banks are programmed through a two-word-per-bank register write port. A bank can be write-protected, in which case a write gets a bus error and no chip-select. A bank can also be qualified by an address-type code. Bank 0 decodes the whole low 256 MB out of reset, with the slowest timing, so that firmware can boot before any register is written. Its port width comes from a strap input sampled during reset.

Top module: `memctl_cs`

## Requirements
- R1: At most one chip-select line is high at any time. When several enabled banks match an access, the lowest-numbered bank is the one selected.
- R2: A bank with size code n (0 to 13) covers 32 KB << n bytes, starting at its base. Only address bits 31 down to 15+n take part in the compare. A written size code above 13 is stored as 13.
- R3: For a bank with wait count N, the access is handled as follows. The chip-select is high from the first cycle after the start cycle through cycle N+1. The acknowledge is high only in cycle N+1. A written wait count of 31 is stored as 30.
- R4: A write that selects a write-protected bank raises no chip-select and no acknowledge. Instead, berr is high for exactly the one cycle after the start cycle. Reads from that bank proceed normally.
- R5: After reset, all outputs are low. Bank 0 is the only enabled bank, with base 0, size code 13, 30 wait states, no protection and no type check. Its width code is taken from boot_width during reset, with 3 treated as 2.
- R6: A bank with type checking enabled responds only when bus_atype equals its programmed 5-bit type. Otherwise the bank is treated as not matching.
- R7: An access that matches no bank raises unmapped for exactly the one cycle after the start cycle, with no chip-select, acknowledge or bus error.
- R8: While the chip-select is high, port_width holds the selected bank's width code (0 = 8-bit, 1 = 16-bit, 2 = 32-bit; a written 3 is stored as 2). It is 0 otherwise.
- R9: While the chip-select is high, a read drives oe high and byte_we low. A write drives oe low and sets byte_we lane i for each byte of the port (lane 0 at byte offset 0) that the access touches. The access size is given by bus_size (0 byte, 1 halfword, 2 or 3 word), clipped to the port width and aligned down to its own size within the port.
- R10: bus_start is ignored while an access is in progress, including its acknowledge cycle. A register write made during an access does not change that access's wait count, width or lanes.
- R11: A write with cfg_word = 0 sets the bank's base (bits 31:15), enable (bit 14), write protect (bit 13), type-check enable (bit 12) and size code (bits 3:0). A write with cfg_word = 1 sets the wait count (bits 4:0), width code (bits 6:5) and address type (bits 11:7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_width | input | 2 | Strap giving bank 0's width code at reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_bank | input | 3 | Bank being written |
| cfg_word | input | 1 | Selects which of the bank's two words is written |
| cfg_wdata | input | 32 | Register write data |
| bus_start | input | 1 | One-cycle start-of-access pulse |
| bus_addr_hi | input | 17 | Address bits 31:15 |
| bus_addr_lo | input | 2 | Address bits 1:0 |
| bus_write | input | 1 | 1 for a write access |
| bus_size | input | 2 | Access size code |
| bus_atype | input | 5 | Address-type code of the access |
| cs | output | 8 | Per-bank chip-select, active high |
| ack | output | 1 | Transfer acknowledge, one cycle |
| berr | output | 1 | Bus error on a protected write |
| unmapped | output | 1 | Access matched no bank |
| port_width | output | 2 | Width code of the selected bank |
| byte_we | output | 4 | Byte-lane write enables |
| oe | output | 1 | Output enable for reads |

## Verification
The bench builds the block with its defaults: eight banks, a 32 KB minimum block, fourteen size steps, a 30-cycle wait limit and 30 boot wait states. These values bring several cases within reach. The full boot window and a clamped size code each span 256 MB. A clamped wait count gives a 31-cycle access. Three overlapping or adjacent banks can be set up at once, so lowest-index priority and the exact 32 KB boundary can be exercised. Every strap value, every port width and every lane pattern is driven as well, and a behavioural model follows every clock.

// File: rtl/memctl_cs.sv
module memctl_cs #(
  parameter int NBANK      = 8,
  parameter int AW         = 32,
  parameter int MIN_SHIFT  = 15,
  parameter int NSIZE      = 14,
  parameter int WAIT_MAX   = 30,
  parameter int BOOT_WAITS = 30,
  parameter int ATW        = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               boot_width,
  input  logic                     cfg_we,
  input  logic [$clog2(NBANK)-1:0] cfg_bank,
  input  logic                     cfg_word,
  input  logic [31:0]              cfg_wdata,
  input  logic                     bus_start,
  input  logic [AW-1:MIN_SHIFT]    bus_addr_hi,
  input  logic [1:0]               bus_addr_lo,
  input  logic                     bus_write,
  input  logic [1:0]               bus_size,
  input  logic [ATW-1:0]           bus_atype,
  output logic [NBANK-1:0]         cs,
  output logic                     ack,
  output logic                     berr,
  output logic                     unmapped,
  output logic [1:0]               port_width,
  output logic [3:0]               byte_we,
  output logic                     oe
);
  localparam int BKW    = $clog2(NBANK);
  localparam int SW     = $clog2(NSIZE);
  localparam int WW     = $clog2(WAIT_MAX + 1);
  localparam int BBW    = AW - MIN_SHIFT;
  localparam int P_VAL  = MIN_SHIFT - 1;
  localparam int P_WP   = MIN_SHIFT - 2;
  localparam int P_ATEN = MIN_SHIFT - 3;
  localparam int P_WID  = WW;
  localparam int P_AT   = WW + 2;
  localparam logic [SW-1:0] SIZE_TOP = SW'(NSIZE - 1);
  localparam logic [WW-1:0] WAIT_TOP = WW'(WAIT_MAX);

  logic [BBW-1:0] base_q  [NBANK];
  logic [SW-1:0]  size_q  [NBANK];
  logic [WW-1:0]  wait_q  [NBANK];
  logic [1:0]     wid_q   [NBANK];
  logic [ATW-1:0] at_q    [NBANK];
  logic           valid_q [NBANK];
  logic           wp_q    [NBANK];
  logic           aten_q  [NBANK];

  logic [SW-1:0] wr_size;
  logic [WW-1:0] wr_wait;
  logic [1:0]    wr_wid, boot_w;

  assign wr_size = (cfg_wdata[SW-1:0] > SIZE_TOP) ? SIZE_TOP : cfg_wdata[SW-1:0];
  assign wr_wait = (cfg_wdata[WW-1:0] > WAIT_TOP) ? WAIT_TOP : cfg_wdata[WW-1:0];
  assign wr_wid  = (cfg_wdata[P_WID+1:P_WID] == 2'd3) ? 2'd2 : cfg_wdata[P_WID+1:P_WID];
  assign boot_w  = (boot_width == 2'd3) ? 2'd2 : boot_width;

  always_ff @(posedge clk) begin
    for (int i = 0; i < NBANK; i++) begin
      if (!rst_n) begin
        valid_q[i] <= (i == 0);
        base_q[i]  <= '0;
        size_q[i]  <= (i == 0) ? SIZE_TOP : '0;
        wait_q[i]  <= (i == 0) ? WW'(BOOT_WAITS) : '0;
        wid_q[i]   <= (i == 0) ? boot_w : 2'd2;
        wp_q[i]    <= 1'b0;
        aten_q[i]  <= 1'b0;
        at_q[i]    <= '0;
      end else if (cfg_we && cfg_bank == BKW'(i)) begin
        if (!cfg_word) begin
          base_q[i]  <= cfg_wdata[AW-1:MIN_SHIFT];
          valid_q[i] <= cfg_wdata[P_VAL];
          wp_q[i]    <= cfg_wdata[P_WP];
          aten_q[i]  <= cfg_wdata[P_ATEN];
          size_q[i]  <= wr_size;
        end else begin
          wait_q[i]  <= wr_wait;
          wid_q[i]   <= wr_wid;
          at_q[i]    <= cfg_wdata[P_AT+ATW-1:P_AT];
        end
      end
    end
  end

  logic [NBANK-1:0] hit;
  logic [BKW-1:0]   sel;
  logic             any;

  always_comb begin
    for (int i = 0; i < NBANK; i++) begin
      logic [BBW-1:0] d;
      d = (bus_addr_hi ^ base_q[i]) & ({BBW{1'b1}} << size_q[i]);
      hit[i] = valid_q[i] && (d == '0) && (!aten_q[i] || at_q[i] == bus_atype);
    end
  end

  always_comb begin
    sel = '0;
    for (int i = NBANK - 1; i >= 0; i--)
      if (hit[i]) sel = BKW'(i);
  end
  assign any = |hit;

  function automatic logic [3:0] lanes(input logic [1:0] w, input logic [1:0] sz,
                                       input logic [1:0] a);
    case (w)
      2'd0:    lanes = 4'b0001;
      2'd1:    lanes = (sz == 2'd0) ? (a[0] ? 4'b0010 : 4'b0001) : 4'b0011;
      default: case (sz)
                 2'd0:    lanes = 4'b0001 << a;
                 2'd1:    lanes = a[1] ? 4'b1100 : 4'b0011;
                 default: lanes = 4'b1111;
               endcase
    endcase
  endfunction

  logic           busy, berr_q, unm_q, cur_oe;
  logic [WW-1:0]  cnt;
  logic [BKW-1:0] cur;
  logic [1:0]     cur_w;
  logic [3:0]     cur_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      cur    <= '0;
      cur_w  <= '0;
      cur_we <= '0;
      cur_oe <= 1'b0;
      berr_q <= 1'b0;
      unm_q  <= 1'b0;
    end else begin
      berr_q <= 1'b0;
      unm_q  <= 1'b0;
      if (busy) begin
        if (cnt == '0) busy <= 1'b0;
        else           cnt  <= cnt - 1'b1;
      end else if (bus_start) begin
        if (!any)
          unm_q <= 1'b1;
        else if (bus_write && wp_q[sel])
          berr_q <= 1'b1;
        else begin
          busy   <= 1'b1;
          cnt    <= wait_q[sel];
          cur    <= sel;
          cur_w  <= wid_q[sel];
          cur_we <= bus_write ? lanes(wid_q[sel], bus_size, bus_addr_lo) : 4'b0000;
          cur_oe <= !bus_write;
        end
      end
    end
  end

  assign cs         = busy ? (NBANK'(1) << cur) : '0;
  assign ack        = busy && (cnt == '0);
  assign berr       = berr_q;
  assign unmapped   = unm_q;
  assign port_width = busy ? cur_w : 2'd0;
  assign byte_we    = busy ? cur_we : 4'b0000;
  assign oe         = busy && cur_oe;
endmodule

// File: rtl/memctl_cs_chk.sv
module memctl_cs_chk #(
  parameter int NBANK = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_start,
  input logic [NBANK-1:0] cs,
  input logic             ack,
  input logic             berr,
  input logic             unmapped,
  input logic [1:0]       port_width,
  input logic [3:0]       byte_we,
  input logic             oe
);
  p_cs_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(cs));
  p_ack_single_r3: assert property (@(posedge clk) disable iff (!rst_n) ack |=> !ack);
  p_ack_has_cs_r3: assert property (@(posedge clk) disable iff (!rst_n) ack |-> $countones(cs) == 1);
  p_berr_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n) berr |-> (cs == '0 && !ack && !unmapped));
  p_berr_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n) berr |=> !berr);
  p_unm_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n) unmapped |-> (cs == '0 && !ack));
  p_unm_started_r7: assert property (@(posedge clk) disable iff (!rst_n) unmapped |-> $past(bus_start));
  p_width_idle_r8: assert property (@(posedge clk) disable iff (!rst_n) (cs == '0) |-> (port_width == 2'd0));
  p_lane_excl_r9: assert property (@(posedge clk) disable iff (!rst_n) !(oe && byte_we != 4'b0000));
  p_cs_hold_r10: assert property (@(posedge clk) disable iff (!rst_n) (cs != '0 && !ack) |=> $stable(cs));
  p_width_hold_r10: assert property (@(posedge clk) disable iff (!rst_n) (cs != '0 && !ack) |=> $stable(port_width));
endmodule

bind memctl_cs memctl_cs_chk #(.NBANK(NBANK)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .cs(cs), .ack(ack), .berr(berr),
  .unmapped(unmapped), .port_width(port_width), .byte_we(byte_we), .oe(oe)
);

// File: tb/sim_memctl_cs.sv
`timescale 1ns/1ps
module sim_memctl_cs;
  localparam int NB = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [1:0]  boot_width = 2'd0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_bank = '0;
  logic        cfg_word = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        bus_start = 1'b0;
  logic [31:0] addr = '0;
  logic        bus_write = 1'b0;
  logic [1:0]  bus_size = '0;
  logic [4:0]  bus_atype = '0;
  logic [NB-1:0] cs;
  logic        ack, berr, unmapped, oe;
  logic [1:0]  port_width;
  logic [3:0]  byte_we;

  memctl_cs u0 (
    .clk(clk), .rst_n(rst_n), .boot_width(boot_width), .cfg_we(cfg_we),
    .cfg_bank(cfg_bank), .cfg_word(cfg_word), .cfg_wdata(cfg_wdata),
    .bus_start(bus_start), .bus_addr_hi(addr[31:15]), .bus_addr_lo(addr[1:0]),
    .bus_write(bus_write), .bus_size(bus_size), .bus_atype(bus_atype),
    .cs(cs), .ack(ack), .berr(berr), .unmapped(unmapped),
    .port_width(port_width), .byte_we(byte_we), .oe(oe)
  );

  int n_chk = 0, n_err = 0;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [31:0] m_base [NB];
  int m_size [NB], m_wait [NB], m_wid [NB], m_at [NB];
  bit m_val [NB], m_wp [NB], m_aten [NB];
  bit m_busy, m_oe, m_berr, m_unm;
  int m_cnt, m_bank, m_w, m_we;

  function automatic int decode(input logic [31:0] a, input int at);
    for (int i = 0; i < NB; i++) begin
      int sh;
      sh = 15 + m_size[i];
      if (m_val[i] && ((a >> sh) == (m_base[i] >> sh)) && (!m_aten[i] || m_at[i] == at))
        return i;
    end
    return -1;
  endfunction

  function automatic int lanes_m(input int w, input int sz, input logic [31:0] a);
    int pb, ab, off;
    pb = 1 << w;
    ab = 1 << ((sz == 3) ? 2 : sz);
    if (ab > pb) ab = pb;
    off = (int'(a[1:0]) % pb) & ~(ab - 1);
    return ((1 << ab) - 1) << off;
  endfunction

  always @(posedge clk) begin : model
    int b, v;
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) begin
        m_base[i] = '0; m_val[i] = (i == 0); m_size[i] = (i == 0) ? 13 : 0;
        m_wait[i] = (i == 0) ? 30 : 0; m_wid[i] = 2; m_wp[i] = 0; m_aten[i] = 0; m_at[i] = 0;
      end
      m_wid[0] = (boot_width == 3) ? 2 : int'(boot_width);
      m_busy = 0; m_berr = 0; m_unm = 0; m_cnt = 0; m_bank = 0; m_w = 0; m_we = 0; m_oe = 0;
    end else begin
      m_berr = 0; m_unm = 0;
      if (m_busy) begin
        if (m_cnt == 0) m_busy = 0; else m_cnt--;
      end else if (bus_start) begin
        b = decode(addr, int'(bus_atype));
        if (b < 0) m_unm = 1;
        else if (bus_write && m_wp[b]) m_berr = 1;
        else begin
          m_busy = 1; m_cnt = m_wait[b]; m_bank = b; m_w = m_wid[b];
          m_we = bus_write ? lanes_m(m_wid[b], int'(bus_size), addr) : 0;
          m_oe = !bus_write;
        end
      end
      if (cfg_we) begin
        if (!cfg_word) begin
          m_base[cfg_bank] = cfg_wdata & 32'hFFFF_8000;
          m_val[cfg_bank]  = cfg_wdata[14];
          m_wp[cfg_bank]   = cfg_wdata[13];
          m_aten[cfg_bank] = cfg_wdata[12];
          v = int'(cfg_wdata[3:0]);
          m_size[cfg_bank] = (v > 13) ? 13 : v;
        end else begin
          v = int'(cfg_wdata[4:0]);
          m_wait[cfg_bank] = (v > 30) ? 30 : v;
          v = int'(cfg_wdata[6:5]);
          m_wid[cfg_bank] = (v == 3) ? 2 : v;
          m_at[cfg_bank] = int'(cfg_wdata[11:7]);
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check("R1 cs", int'(cs), m_busy ? (1 << m_bank) : 0);
      check("R3 ack", int'(ack), int'(m_busy && m_cnt == 0));
      check("R4 berr", int'(berr), int'(m_berr));
      check("R7 unmapped", int'(unmapped), int'(m_unm));
      check("R8 port_width", int'(port_width), m_busy ? m_w : 0);
      check("R9 byte_we", int'(byte_we), m_busy ? m_we : 0);
      check("R9 oe", int'(oe), int'(m_busy && m_oe));
    end
  end

  function automatic logic [31:0] w0(input logic [31:0] b, input bit v, input bit wp,
                                      input bit aten, input int sz);
    return (b & 32'hFFFF_8000) | (32'(v) << 14) | (32'(wp) << 13) | (32'(aten) << 12) | 32'(sz & 15);
  endfunction

  function automatic logic [31:0] w1(input int wt, input int wid, input int at);
    return 32'(wt & 31) | (32'(wid & 3) << 5) | (32'(at & 31) << 7);
  endfunction

  task automatic cfg(input int bank, input bit word, input logic [31:0] d);
    cfg_we = 1; cfg_bank = 3'(bank); cfg_word = word; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  int lat, kind, cs_s, pw_s, bwe_s, oe_s;

  task automatic acc(input logic [31:0] a, input bit wr, input int sz, input int at);
    addr = a; bus_write = wr; bus_size = 2'(sz); bus_atype = 5'(at); bus_start = 1;
    @(negedge clk);
    bus_start = 0;
    lat = 1; kind = 0;
    for (int k = 0; k < 40; k++) begin
      if (ack) kind = 1; else if (berr) kind = 2; else if (unmapped) kind = 3;
      if (kind != 0) break;
      @(negedge clk); lat++;
    end
    cs_s = int'(cs); pw_s = int'(port_width); bwe_s = int'(byte_we); oe_s = int'(oe);
    @(negedge clk);
  endtask

  task automatic do_reset(input int strap);
    rst_n = 0; boot_width = 2'(strap);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R3 watchdog: actual=hung expected=run complete");
    summary();
    $finish;
  end

  initial begin
    @(negedge clk);
    // R5: reset state and boot bank
    do_reset(1);
    check("R5 reset cs", int'(cs), 0);
    check("R5 reset ack/berr/unmapped", int'({ack, berr, unmapped}), 0);
    check("R5 reset lanes", int'({oe, byte_we, port_width}), 0);
    acc(32'h0012_3456, 0, 2, 0);
    check("R5 boot kind", kind, 1);
    check("R3 boot latency", lat, 31);
    check("R5 boot cs", cs_s, 1);
    check("R5 strap 16-bit", pw_s, 1);
    acc(32'h0FFF_FFFC, 0, 2, 0);
    check("R5 boot top of 256MB", kind, 1);
    acc(32'h1000_0000, 0, 2, 0);
    check("R5 boot above window", kind, 3);
    do_reset(0);
    acc(32'h0000_0100, 1, 2, 0);
    check("R5 strap 8-bit", pw_s, 0);
    check("R9 8-bit word write lanes", bwe_s, 1);
    do_reset(3);
    acc(32'h0000_0100, 0, 2, 0);
    check("R5 strap 3 read as 32-bit", pw_s, 2);
    do_reset(2);
    acc(32'h0000_0100, 0, 2, 0);
    check("R5 strap 32-bit", pw_s, 2);

    // R2 / R11: small bank and its boundary
    cfg(1, 0, w0(32'h1000_0000, 1, 0, 0, 0));
    cfg(1, 1, w1(2, 2, 0));
    acc(32'h1000_7FFC, 0, 2, 0);
    check("R2 last word of 32KB", kind, 1);
    check("R3 two waits latency", lat, 3);
    check("R2 bank1 cs", cs_s, 2);
    acc(32'h1000_8000, 0, 2, 0);
    check("R7 just past 32KB", kind, 3);

    // R1: overlapping banks, lowest wins
    cfg(2, 0, w0(32'h1000_0000, 1, 0, 0, 4));
    cfg(2, 1, w1(0, 1, 0));
    acc(32'h1000_0004, 0, 2, 0);
    check("R1 overlap lowest bank", cs_s, 2);
    acc(32'h1001_0000, 0, 2, 0);
    check("R1 second bank cs", cs_s, 4);
    check("R3 zero waits latency", lat, 1);
    check("R8 16-bit width", pw_s, 1);

    // R2: size clamp
    cfg(5, 0, w0(32'h4000_0000, 1, 0, 0, 15));
    acc(32'h4FFF_FFF0, 0, 2, 0);
    check("R2 clamped size covers 256MB", kind, 1);
    acc(32'h5000_0000, 0, 2, 0);
    check("R2 clamped size ends at 256MB", kind, 3);

    // R4: write protection
    cfg(3, 0, w0(32'h2000_0000, 1, 1, 0, 0));
    cfg(3, 1, w1(1, 2, 0));
    acc(32'h2000_0010, 1, 2, 0);
    check("R4 protected write -> berr", kind, 2);
    check("R4 protected write no cs", cs_s, 0);
    acc(32'h2000_0010, 0, 2, 0);
    check("R4 protected read ok", kind, 1);
    check("R4 protected read latency", lat, 2);

    // R6: address type
    cfg(4, 0, w0(32'h3000_0000, 1, 0, 1, 2));
    cfg(4, 1, w1(0, 2, 5));
    acc(32'h3000_0040, 0, 2, 5);
    check("R6 type match", kind, 1);
    acc(32'h3000_0040, 0, 2, 2);
    check("R6 type mismatch", kind, 3);

    // R3: wait clamp
    cfg(6, 0, w0(32'h6000_0000, 1, 0, 0, 0));
    cfg(6, 1, w1(31, 2, 0));
    acc(32'h6000_0000, 0, 2, 0);
    check("R3 wait 31 clamped to 30", lat, 31);

    // R9 / R8: byte lanes
    acc(32'h1001_0001, 1, 0, 0);
    check("R9 16-bit odd byte", bwe_s, 2);
    acc(32'h1000_0002, 1, 1, 0);
    check("R9 32-bit upper half", bwe_s, 12);
    acc(32'h1000_0003, 1, 0, 0);
    check("R9 32-bit byte 3", bwe_s, 8);
    acc(32'h1000_0000, 1, 3, 0);
    check("R9 size 3 as word", bwe_s, 15);
    acc(32'h1000_0000, 0, 0, 0);
    check("R9 read oe", oe_s, 1);
    check("R9 read no write lanes", bwe_s, 0);
    cfg(7, 0, w0(32'h7000_0000, 1, 0, 0, 0));
    cfg(7, 1, w1(0, 0, 0));
    acc(32'h7000_0002, 1, 2, 0);
    check("R8 8-bit width", pw_s, 0);
    check("R9 8-bit lane", bwe_s, 1);

    // R10: mid-access config change and ignored start
    addr = 32'h1000_0000; bus_write = 0; bus_size = 2; bus_atype = 0; bus_start = 1;
    @(negedge clk);
    check("R10 cycle1 ack low", int'(ack), 0);
    cfg_we = 1; cfg_bank = 1; cfg_word = 1; cfg_wdata = w1(0, 0, 0);
    addr = 32'h9000_0000; bus_start = 1;
    @(negedge clk);
    cfg_we = 0; bus_start = 0;
    check("R10 cycle2 ack low", int'(ack), 0);
    check("R10 ignored start no unmapped", int'(unmapped), 0);
    check("R10 width kept", int'(port_width), 2);
    @(negedge clk);
    check("R10 old wait count kept", int'(ack), 1);
    @(negedge clk);
    check("R10 access ended", int'(cs), 0);
    @(negedge clk);
    check("R10 no second access", int'({ack, unmapped}), 0);
    acc(32'h1000_0000, 0, 2, 0);
    check("R10 new wait count applies next access", lat, 1);
    check("R11 new width applies next access", pw_s, 0);
    cfg(1, 1, w1(2, 2, 0));

    // mixed traffic
    for (int n = 0; n < 300; n++) begin
      logic [31:0] a;
      int sel, b, ek;
      bit wr;
      sel = int'($urandom % 9);
      case (sel)
        0: a = 32'h0000_0000; 1: a = 32'h1000_0000; 2: a = 32'h1001_0000;
        3: a = 32'h2000_0000; 4: a = 32'h3000_0000; 5: a = 32'h4000_0000;
        6: a = 32'h6000_0000; 7: a = 32'h7000_0000; default: a = 32'h9000_0000;
      endcase
      a = a | ($urandom & 32'h0000_FFFF);
      wr = 1'($urandom);
      b = decode(a, (sel == 4) ? 5 : 0);
      ek = (b < 0) ? 3 : ((wr && m_wp[b]) ? 2 : 1);
      acc(a, wr, int'($urandom % 4), (sel == 4) ? 5 : 0);
      check("R4 R7 access outcome", kind, ek);
    end

    summary();
    $finish;
  end
endmodule